// File: doc/BRIEF.md
# Single-Cycle 32-bit Subset RISC Core

This block is a small 32-bit processor core that completes one instruction per clock. It handles ten instructions: register add and subtract, add-immediate, shift-left-logical, word load and word store, branch-on-equal, branch-on-not-equal, absolute jump and jump-through-register. There are three 32-bit encodings. The register format names two source registers, a destination and a shift amount. The immediate format names two registers and a signed 16-bit constant. The jump format carries a 26-bit word address. The core holds the program counter, a register file of 32 words with a hardwired zero entry, the decoder, the ALU and the next-PC selection.

Instructions come from a synchronous-read memory. The core puts the address of the next instruction on `imem_addr`, and the memory returns that word on `imem_rdata` after the next rising edge, which is the cycle in which the core executes it. The data memory port reads combinationally, so a load finishes in the same cycle. Stores are written at the clock edge that ends the cycle.

Top module: `trc_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the program counter is set to 0x00400000, every register is cleared, `imem_addr` shows 0x00400000 and `dmem_we` stays low.
- R2: An instruction that does not redirect control advances the PC by 4.
- R3: With opcode 0 (bits 31:26) and funct 0x20 or 0x22 (bits 5:0), the core writes rs+rt or rs-rt into rd. Here rs is bits 25:21, rt is bits 20:16 and rd is bits 15:11.
- R4: With opcode 0 and funct 0x00, rd receives rt shifted left by shamt (bits 10:6).
- R5: Opcode 0x08 writes rs plus the sign-extended imm (bits 15:0) into rt.
- R6: Opcode 0x23 loads into rt and opcode 0x2B stores rt. The data address in both cases is rs plus the sign-extended imm.
- R7: Register 0 reads as zero, and any write to it is discarded.
- R8: Opcode 0x04 (equal) or 0x05 (not equal) compares rs with rt. When the condition holds, the next PC is PC+4 plus the sign-extended imm shifted left by 2. Backward offsets work.
- R9: Opcode 0x02 sets the next PC to the upper 4 bits of PC+4, followed by the 26-bit field, followed by two zero bits.
- R10: Opcode 0 with funct 0x08 sets the next PC to the value of rs.
- R11: Any other opcode, or any other funct with opcode 0, changes no register and no memory. It only advances the PC.
- R12: `imem_addr` presents the address of the next instruction, and the word fetched from it is executed in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Byte address of the next instruction |
| imem_rdata | input | 32 | Instruction word, registered by the memory |
| dmem_addr | output | 32 | Data byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store enable, acting at the rising edge |
| dmem_rdata | input | 32 | Load data, combinational |

## Verification
Every instruction produces its effect within its own cycle. Stores appear on the data port during the cycle the instruction executes. `imem_addr` already shows the chosen next address before the edge that ends that cycle. Register results become visible one cycle later, when a following store reads them. The bench therefore records each store at the falling edge of the cycle in which it occurs, and it judges branches and jumps by which stores appear and in what order. It reads `imem_addr` half a cycle after reset is released, and again at the final self-jump.

// File: rtl/trc_pkg.sv
// Shared encodings and control word for the subset core.
// Assumes 32-bit instructions with the opcode in bits 31:26.
package trc_pkg;
    localparam int XLEN = 32;

    localparam logic [5:0] OP_REG  = 6'h00;
    localparam logic [5:0] OP_ADDI = 6'h08;
    localparam logic [5:0] OP_LW   = 6'h23;
    localparam logic [5:0] OP_SW   = 6'h2B;
    localparam logic [5:0] OP_BEQ  = 6'h04;
    localparam logic [5:0] OP_BNE  = 6'h05;
    localparam logic [5:0] OP_J    = 6'h02;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_SLL = 6'h00;
    localparam logic [5:0] FN_JR  = 6'h08;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_SLL} alu_op_e;

    typedef struct packed {
        logic    reg_we;
        logic    dst_is_rd;
        logic    use_imm;
        alu_op_e alu_op;
        logic    mem_we;
        logic    load;
        logic    br_eq;
        logic    br_ne;
        logic    jmp;
        logic    jreg;
    } ctrl_t;
endpackage

// File: rtl/trc_regfile.sv
// Register file with two combinational read ports and one write port.
// Entry 0 is never written, so it keeps its reset value of zero.
// Assumes a synchronous active-low reset that clears every entry.
module trc_regfile #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ra_a,
    input  logic [AW-1:0]    ra_b,
    output logic [WIDTH-1:0] rd_a,
    output logic [WIDTH-1:0] rd_b,
    input  logic             we,
    input  logic [AW-1:0]    wa,
    input  logic [WIDTH-1:0] wd
);
    logic [WIDTH-1:0] regs_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Each entry clears on reset and takes a write addressed to it, except entry 0.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (we && wa == AW'(g) && g != 0)
                regs_q[g] <= wd;
        end
    end

    // Read ports index the array directly.
    assign rd_a = regs_q[ra_a];
    assign rd_b = regs_q[ra_b];

    AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_a == '0) |-> (rd_a == '0)); // R7
endmodule

// File: rtl/trc_decode.sv
// Turns opcode and funct into the control word.
// Unknown codes yield an all-inactive word, so the instruction acts as a no-op.
module trc_decode
    import trc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    // Select control fields for each supported encoding.
    always_comb begin
        ctrl = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (opcode)
            OP_REG: begin
                unique case (funct)
                    FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; end
                    FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_SUB; end
                    FN_SLL: begin ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_SLL; end
                    FN_JR:  ctrl.jreg = 1'b1;
                    default: ;
                endcase
            end
            OP_ADDI: begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; end
            OP_LW:   begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.load = 1'b1; end
            OP_SW:   begin ctrl.mem_we = 1'b1; ctrl.use_imm = 1'b1; end
            OP_BEQ:  ctrl.br_eq = 1'b1;
            OP_BNE:  ctrl.br_ne = 1'b1;
            OP_J:    ctrl.jmp = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/trc_alu.sv
// Add, subtract and shift-left unit. The shift applies to operand b.
module trc_alu
    import trc_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SW = $clog2(WIDTH)
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [SW-1:0]    shamt,
    output logic [WIDTH-1:0] y
);
    // Compute the selected operation.
    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_SLL: y = b << shamt;
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/trc_nextpc.sv
// Chooses the next program counter: sequential, branch, jump or register jump.
// Assumes at most one redirect request is active at a time.
module trc_nextpc #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16,
    parameter int JA_W  = 26
) (
    input  logic [WIDTH-1:0] pc,
    input  logic [IMM_W-1:0] imm,
    input  logic [JA_W-1:0]  jaddr,
    input  logic [WIDTH-1:0] reg_target,
    input  logic             take_br,
    input  logic             jmp,
    input  logic             jreg,
    output logic [WIDTH-1:0] npc
);
    localparam int HI_W = WIDTH - JA_W - 2;

    logic [WIDTH-1:0] pc_plus4;
    logic [WIDTH-1:0] br_off;

    assign pc_plus4 = pc + WIDTH'(4);
    assign br_off   = {{(WIDTH-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};

    // Priority-free select, because the requests never overlap.
    always_comb begin
        npc = pc_plus4;
        if (take_br) npc = pc_plus4 + br_off;
        if (jmp)     npc = {pc_plus4[WIDTH-1 -: HI_W], jaddr, 2'b00};
        if (jreg)    npc = reg_target;
    end
endmodule

// File: rtl/trc_core.sv
// Single-cycle subset core. It executes one instruction per clock.
// Assumes the instruction memory registers imem_addr at each edge, and the
// data memory reads combinationally and writes at the edge.
module trc_core
    import trc_pkg::*;
#(
    parameter logic [31:0] RESET_PC  = 32'h0040_0000,
    parameter int          REG_COUNT = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata
);
    localparam int RA_W = $clog2(REG_COUNT);
    localparam int SH_W = $clog2(XLEN);

    logic [XLEN-1:0] pc_q, pc_next;
    logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, imm_ext, wb_data;
    logic [RA_W-1:0] dst;
    logic            take_br, redirect;
    ctrl_t           ctrl;

    wire [5:0]  f_op    = imem_rdata[31:26];
    wire [4:0]  f_rs    = imem_rdata[25:21];
    wire [4:0]  f_rt    = imem_rdata[20:16];
    wire [4:0]  f_rd    = imem_rdata[15:11];
    wire [4:0]  f_sh    = imem_rdata[10:6];
    wire [5:0]  f_fn    = imem_rdata[5:0];
    wire [15:0] f_imm   = imem_rdata[15:0];
    wire [25:0] f_jaddr = imem_rdata[25:0];

    trc_decode i_dec (.opcode(f_op), .funct(f_fn), .ctrl(ctrl));

    assign dst     = ctrl.dst_is_rd ? RA_W'(f_rd) : RA_W'(f_rt);
    assign wb_data = ctrl.load ? dmem_rdata : alu_y;

    trc_regfile #(.DEPTH(REG_COUNT), .WIDTH(XLEN)) i_rf (
        .clk(clk), .rst_n(rst_n),
        .ra_a(RA_W'(f_rs)), .ra_b(RA_W'(f_rt)),
        .rd_a(rs_val), .rd_b(rt_val),
        .we(ctrl.reg_we & rst_n), .wa(dst), .wd(wb_data)
    );

    assign imm_ext = {{(XLEN-16){f_imm[15]}}, f_imm};
    assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

    trc_alu #(.WIDTH(XLEN)) i_alu (
        .op(ctrl.alu_op), .a(rs_val), .b(alu_b), .shamt(SH_W'(f_sh)), .y(alu_y)
    );

    assign take_br  = (ctrl.br_eq & (rs_val == rt_val)) | (ctrl.br_ne & (rs_val != rt_val));
    assign redirect = take_br | ctrl.jmp | ctrl.jreg;

    trc_nextpc #(.WIDTH(XLEN), .IMM_W(16), .JA_W(26)) i_npc (
        .pc(pc_q), .imm(f_imm), .jaddr(f_jaddr), .reg_target(rs_val),
        .take_br(take_br), .jmp(ctrl.jmp), .jreg(ctrl.jreg), .npc(pc_next)
    );

    // Program counter: reset vector on reset, otherwise the selected next address.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= pc_next;
    end

    assign imem_addr  = rst_n ? pc_next : RESET_PC;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_we & rst_n;

    AST_RESET_VECTOR: assert property (@(posedge clk)
        !rst_n |=> (pc_q == RESET_PC)); // R1
    AST_NO_STORE_IN_RESET: assert property (@(posedge clk)
        !rst_n |-> !dmem_we); // R1
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |=> (pc_q == $past(pc_q) + 32'd4)); // R2
    AST_SUB_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.alu_op == ALU_SUB && ctrl.reg_we) |-> (alu_y + rt_val == rs_val)); // R3
    AST_ONE_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_br, ctrl.jmp, ctrl.jreg})); // R8
endmodule

// File: tb/test_trc_core.sv
`timescale 1ns/1ps
module test_trc_core;
    localparam logic [31:0] RST_PC = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    logic [31:0] log_a [32];
    logic [31:0] log_d [32];
    int          log_n = 0;
    int          n_run = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    trc_core i_trc_core (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
    );

    // Synchronous-read instruction memory; out-of-range fetches return a no-op.
    initial imem_rdata = 32'd0;
    always @(posedge clk) begin
        logic [31:0] off;
        off = imem_addr - RST_PC;
        imem_rdata <= (off < 32'd256) ? imem[off[7:2]] : 32'd0;
    end

    assign dmem_rdata = dmem[dmem_addr[7:2]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    // Record every store in the cycle it is presented.
    always @(negedge clk) begin
        if (rst_n && dmem_we && log_n < 32) begin
            log_a[log_n] = dmem_addr;
            log_d[log_n] = dmem_wdata;
            log_n++;
        end
    end

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int idx);
        logic [31:0] a;
        a = RST_PC + 32'(idx * 4);
        return {6'h02, a[27:2]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected stores in order: {tag, address, data}.
    localparam logic [95:0] EXP [10] = '{
        {"R3  ", 32'd0,  32'h0000_0002},   // add
        {"R3  ", 32'd4,  32'h0000_0008},   // sub with negative operand
        {"R4  ", 32'd8,  32'h0000_0050},   // sll by 4
        {"R7  ", 32'd12, 32'h0000_0000},   // register 0 after a write attempt
        {"R5  ", 32'd28, 32'hFFFF_FFFD},   // negative addi value, negative store offset (R6)
        {"R6  ", 32'd32, 32'h0000_0008},   // value loaded back from address 4
        {"R8  ", 32'd40, 32'h0000_0005},   // beq skipped two stores, bne fell through
        {"R10 ", 32'd48, 32'h0040_006C},   // register jump landed, j skipped two stores (R9)
        {"R11 ", 32'd52, 32'h0000_0002},   // unsupported codes left r10 alone
        {"R8  ", 32'd56, 32'h0000_0003}    // backward bne loop ran three times
    };

    task automatic check_log();
        check(log_n == 10, "R8 store count", 32'(log_n), 32'd10);
        for (int i = 0; i < 10; i++) begin
            if (i < log_n) begin
                check(log_a[i] == EXP[i][63:32], string'(EXP[i][95:64]), log_a[i], EXP[i][63:32]);
                check(log_d[i] == EXP[i][31:0],  string'(EXP[i][95:64]), log_d[i], EXP[i][31:0]);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin imem[i] = 32'd0; dmem[i] = 32'd0; end
        imem[0]  = enc_i(6'h08, 0, 8, 5);
        imem[1]  = enc_i(6'h08, 0, 9, -3);
        imem[2]  = enc_r(8, 9, 10, 0, 6'h20);
        imem[3]  = enc_r(8, 9, 11, 0, 6'h22);
        imem[4]  = enc_r(0, 8, 12, 4, 6'h00);
        imem[5]  = enc_i(6'h08, 0, 0, 7);
        imem[6]  = enc_i(6'h2B, 0, 10, 0);
        imem[7]  = enc_i(6'h2B, 0, 11, 4);
        imem[8]  = enc_i(6'h2B, 0, 12, 8);
        imem[9]  = enc_i(6'h2B, 0, 0, 12);
        imem[10] = enc_i(6'h08, 0, 13, 32);
        imem[11] = enc_i(6'h2B, 13, 9, -4);
        imem[12] = enc_i(6'h23, 0, 14, 4);
        imem[13] = enc_i(6'h2B, 0, 14, 32);
        imem[14] = enc_i(6'h04, 11, 14, 2);
        imem[15] = enc_i(6'h2B, 0, 8, 36);
        imem[16] = enc_i(6'h2B, 0, 8, 36);
        imem[17] = enc_i(6'h05, 11, 14, 5);
        imem[18] = enc_i(6'h2B, 0, 8, 40);
        imem[19] = enc_j(22);
        imem[20] = enc_i(6'h2B, 0, 8, 44);
        imem[21] = enc_i(6'h2B, 0, 8, 44);
        imem[22] = enc_i(6'h08, 0, 15, 16'h40);
        imem[23] = enc_r(0, 15, 15, 16, 6'h00);
        imem[24] = enc_i(6'h08, 15, 15, 108);
        imem[25] = enc_r(15, 0, 0, 0, 6'h08);
        imem[26] = enc_i(6'h2B, 0, 8, 48);
        imem[27] = enc_i(6'h2B, 0, 15, 48);
        imem[28] = enc_i(6'h3F, 8, 10, 1);
        imem[29] = enc_r(8, 8, 10, 0, 6'h3F);
        imem[30] = enc_i(6'h2B, 0, 10, 52);
        imem[31] = enc_i(6'h08, 16, 16, 1);
        imem[32] = enc_i(6'h08, 0, 17, 3);
        imem[33] = enc_i(6'h05, 16, 17, -3);
        imem[34] = enc_i(6'h2B, 0, 16, 56);
        imem[35] = enc_j(35);

        // Reset state, observed between edges.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(imem_addr == RST_PC, "R1 reset address", imem_addr, RST_PC);
        check(dmem_we == 1'b0, "R1 no store in reset", 32'(dmem_we), 32'd0);
        rst_n = 1'b1;
        #1;
        check(imem_addr == RST_PC + 32'd4, "R12 next fetch address", imem_addr, RST_PC + 32'd4);
        check(imem_addr == RST_PC + 32'd4, "R2 sequential step", imem_addr, RST_PC + 32'd4);

        // Walk the expected-store table.
        repeat (80) @(posedge clk);
        @(negedge clk);
        check_log();
        check(imem_addr == 32'h0040_008C, "R9 self jump", imem_addr, 32'h0040_008C);
        @(negedge clk);
        check(imem_addr == 32'h0040_008C, "R9 self jump held", imem_addr, 32'h0040_008C);

        // Reset in mid-run: registers must clear so the loop count repeats.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(imem_addr == RST_PC, "R1 mid-run reset address", imem_addr, RST_PC);
        check(dmem_we == 1'b0, "R1 mid-run no store", 32'(dmem_we), 32'd0);
        log_n = 0;
        rst_n = 1'b1;
        repeat (80) @(posedge clk);
        @(negedge clk);
        check(log_n == 10, "R1 rerun store count", 32'(log_n), 32'd10);
        if (log_n == 10)
            check(log_d[9] == 32'd3, "R1 registers cleared", log_d[9], 32'd3);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule